// File: doc/BRIEF.md
# Photon Coincidence Counter with Serial Report

This block counts detections from two single-photon detectors. A build parameter adds a third detector. It also counts coincidences, where every enabled detector fires within a short programmable window. Detector pulses arrive asynchronously to the 100 MHz system clock. Each input passes through a two-flop synchronizer and a rising-edge detector. A pulse is therefore counted once, whatever its width, and time is resolved to 10 ns bins.

When a channel produces an edge, it stays armed for a programmable number of cycles. A coincidence is recorded in the cycle where every enabled channel is armed or has an edge. All armed states are then dropped, so one group of photons is counted only once.

Singles counts and the coincidence count build up over a fixed integration period and are then captured. The captured values go out on an 8N1 serial line as one frame per period. A host reads the frames through a USB-to-serial bridge. If a frame is not finished when the next one is ready, the newer frame is discarded and a sticky flag is raised.

Top module: `coinc_counter_top`

## Requirements
- R1: Each detector input passes through two synchronizing flops before edge detection. A pulse of any width (held high for at least one clock) adds exactly one to that channel's count.
- R2: Each channel keeps a singles count of its rising edges within the current integration period.
- R3: Let the window setting W be `win_len`, with 0 treated as 1. An edge on one enabled channel followed d cycles later by an edge on the other is a coincidence when d <= W and is not one when d > W, in either order. A later edge on the same channel restarts that channel's window.
- R4: A coincidence drops every channel's armed state. An edge that follows, while the other channel is not armed again, adds no second coincidence.
- R5: Bit c of `ch_en` set to 1 makes channel c required for a coincidence. A disabled channel is ignored by the coincidence test but is still counted as singles. With a single enabled channel, every edge on it is a coincidence. With no channel enabled, no coincidence is counted.
- R6: Every PERIOD_CYCLES clocks, all counts are captured and reset to zero. Events inside a period appear in that period's frame.
- R7: Counts saturate at 2^CNT_W-1 and do not wrap.
- R8: A frame is byte 0xA5, then each captured count as CNT_W/8 bytes, least significant byte first. The counts are sent in channel order, ch0 first, and the coincidence count last.
- R9: `uart_tx` is 8N1: a 0 start bit, 8 data bits LSB first, and a 1 stop bit. Each bit lasts BAUD_DIV clocks. The bytes of a frame follow each other back to back, and the line is high when idle.
- R10: A frame that becomes ready while the previous one is still being sent is dropped, and `overflow` goes to 1. `overflow` stays at 1 until reset.
- R11: After reset, `uart_tx` is 1, `overflow` is 0 and all counts are zero. The first frame therefore carries zero counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 100 MHz sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| det_in | input | NUM_CH | Detector pulses, asynchronous to clk |
| ch_en | input | NUM_CH | Channels required for a coincidence |
| win_len | input | WIN_W | Coincidence window in cycles (0 acts as 1) |
| uart_tx | output | 1 | Serial frame output, 8N1 |
| overflow | output | 1 | Sticky flag, set when a frame was dropped |

## Verification
Detector pairs are driven with separations of 0 up to W, then W+1 and beyond, in both orders. This separates an inclusive window from an exclusive one and exposes an off-by-one in the window load. A long pulse overlapping a short one shows whether the count follows edges or levels. A repeated edge right after a coincidence shows whether disarming works. An early edge later rearmed shows whether a window restarts. Changing `ch_en` to one channel and then to none separates the enable logic from the pairing logic.

A second instance with narrow counters, three channels and a short period lets a single channel saturate. It also makes a report overrun the next period, which checks both the dropped frame and the three-channel frame layout.

// File: rtl/coinc_pkg.sv
package coinc_pkg;

  localparam logic [7:0] FRAME_SYNC = 8'hA5;

  // Bytes in one report frame: sync byte plus one count per channel and one for coincidences.
  function automatic int frame_bytes(input int n_ch, input int cnt_w);
    return 1 + (n_ch + 1) * (cnt_w / 8);
  endfunction

endpackage

// File: rtl/det_sync.sv
module det_sync #(
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] det_in,
  output logic [NUM_CH-1:0] rise
);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    // [0],[1] synchronize; [2] remembers the previous synchronized level
    logic [2:0] pipe_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q <= '0;
      else        pipe_q <= {pipe_q[1:0], det_in[c]};
    end
    assign rise[c] = pipe_q[1] & ~pipe_q[2];
  end

endmodule

// File: rtl/coinc_window.sv
module coinc_window #(
  parameter int NUM_CH = 2,
  parameter int WIN_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] rise,
  input  logic [NUM_CH-1:0] ch_en,
  input  logic [WIN_W-1:0]  win_len,
  output logic [NUM_CH-1:0] armed,
  output logic              coinc
);

  // A zero setting would never arm; treat it as the shortest window.
  function automatic logic [WIN_W-1:0] span_load(input logic [WIN_W-1:0] w);
    return (w == '0) ? WIN_W'(1) : w;
  endfunction

  logic [NUM_CH-1:0] live;
  assign live  = rise | armed;
  assign coinc = (|ch_en) & (&(live | ~ch_en));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_arm
    logic [WIN_W-1:0] left_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             left_q <= '0;
      else if (coinc)         left_q <= '0;
      else if (rise[c])       left_q <= span_load(win_len);
      else if (left_q != '0)  left_q <= left_q - WIN_W'(1);
    end
    assign armed[c] = (left_q != '0);
  end

endmodule

// File: rtl/count_bank.sv
module count_bank #(
  parameter int NUM_CH        = 2,
  parameter int CNT_W         = 32,
  parameter int PERIOD_CYCLES = 1000
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_CH-1:0]            rise,
  input  logic                         coinc,
  output logic [(NUM_CH+1)*CNT_W-1:0]  payload,
  output logic                         frame_ready,
  output logic                         period_end,
  output logic [CNT_W-1:0]             coinc_run
);

  localparam int NSLOT = NUM_CH + 1;
  localparam int PER_W = (PERIOD_CYCLES > 1) ? $clog2(PERIOD_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  function automatic logic [CNT_W-1:0] sat_step(input logic [CNT_W-1:0] v, input logic e);
    return (e && (v != CNT_MAX)) ? v + CNT_W'(1) : v;
  endfunction

  logic [PER_W-1:0] per_q;
  assign period_end = (per_q == PER_W'(PERIOD_CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q       <= '0;
      frame_ready <= 1'b0;
    end else begin
      per_q       <= period_end ? '0 : per_q + PER_W'(1);
      frame_ready <= period_end;
    end
  end

  logic [NSLOT-1:0] ev;
  assign ev = {coinc, rise};

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    logic [CNT_W-1:0] run_q, snap_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        run_q  <= '0;
        snap_q <= '0;
      end else if (period_end) begin
        snap_q <= sat_step(run_q, ev[s]);
        run_q  <= '0;
      end else begin
        run_q  <= sat_step(run_q, ev[s]);
      end
    end
    assign payload[s*CNT_W +: CNT_W] = snap_q;
    if (s == NSLOT - 1) begin : g_last
      assign coinc_run = run_q;
    end
  end

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx #(
  parameter int NUM_CH   = 2,
  parameter int CNT_W    = 32,
  parameter int BAUD_DIV = 868
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        frame_ready,
  input  logic [(NUM_CH+1)*CNT_W-1:0] payload,
  output logic                        tx,
  output logic                        busy,
  output logic                        overflow
);

  import coinc_pkg::*;

  localparam int NBYTES = frame_bytes(NUM_CH, CNT_W);
  localparam int IDX_W  = $clog2(NBYTES);
  localparam int BD_W   = $clog2(BAUD_DIV);
  localparam int PAY_W  = (NUM_CH + 1) * CNT_W;

  function automatic logic [7:0] pick_byte(input logic [PAY_W-1:0] pay, input logic [IDX_W-1:0] k);
    logic [PAY_W-1:0] sh;
    if (k == '0) return FRAME_SYNC;
    sh = pay >> (8 * (int'(k) - 1));
    return sh[7:0];
  endfunction

  logic             busy_q, ovf_q;
  logic [PAY_W-1:0] pay_q;
  logic [IDX_W-1:0] idx_q;
  logic [9:0]       shift_q;
  logic [3:0]       bit_q;
  logic [BD_W-1:0]  baud_q;

  logic last_tick, frame_done;
  assign last_tick  = busy_q && (baud_q == BD_W'(BAUD_DIV - 1));
  assign frame_done = (bit_q == 4'd9) && (idx_q == IDX_W'(NBYTES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      ovf_q   <= 1'b0;
      pay_q   <= '0;
      idx_q   <= '0;
      shift_q <= '1;
      bit_q   <= '0;
      baud_q  <= '0;
    end else begin
      if (frame_ready && busy_q) ovf_q <= 1'b1;
      if (!busy_q) begin
        if (frame_ready) begin
          busy_q  <= 1'b1;
          pay_q   <= payload;
          idx_q   <= '0;
          shift_q <= {1'b1, FRAME_SYNC, 1'b0};
          bit_q   <= '0;
          baud_q  <= '0;
        end
      end else if (!last_tick) begin
        baud_q <= baud_q + BD_W'(1);
      end else begin
        baud_q <= '0;
        if (bit_q == 4'd9) begin
          if (frame_done) begin
            busy_q <= 1'b0;
          end else begin
            idx_q   <= idx_q + IDX_W'(1);
            shift_q <= {1'b1, pick_byte(pay_q, idx_q + IDX_W'(1)), 1'b0};
            bit_q   <= '0;
          end
        end else begin
          shift_q <= {1'b1, shift_q[9:1]};
          bit_q   <= bit_q + 4'd1;
        end
      end
    end
  end

  assign tx       = busy_q ? shift_q[0] : 1'b1;
  assign busy     = busy_q;
  assign overflow = ovf_q;

endmodule

// File: rtl/coinc_counter_top.sv
module coinc_counter_top #(
  parameter int NUM_CH        = 2,
  parameter int CNT_W         = 32,
  parameter int WIN_W         = 4,
  parameter int PERIOD_CYCLES = 100_000_000,
  parameter int BAUD_DIV      = 868
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] det_in,
  input  logic [NUM_CH-1:0] ch_en,
  input  logic [WIN_W-1:0]  win_len,
  output logic              uart_tx,
  output logic              overflow
);

  localparam int PAY_W = (NUM_CH + 1) * CNT_W;

  // Named internal events, visible to the bound checker
  logic [NUM_CH-1:0] edge_vec;
  logic [NUM_CH-1:0] armed_vec;
  logic              coinc_pulse;
  logic              period_end;
  logic              frame_ready;
  logic              tx_busy;
  logic [CNT_W-1:0]  coinc_run;
  logic [PAY_W-1:0]  payload;

  det_sync #(.NUM_CH(NUM_CH)) u_sync (
    .clk(clk), .rst_n(rst_n), .det_in(det_in), .rise(edge_vec)
  );

  coinc_window #(.NUM_CH(NUM_CH), .WIN_W(WIN_W)) u_win (
    .clk(clk), .rst_n(rst_n), .rise(edge_vec), .ch_en(ch_en),
    .win_len(win_len), .armed(armed_vec), .coinc(coinc_pulse)
  );

  count_bank #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .PERIOD_CYCLES(PERIOD_CYCLES)) u_cnt (
    .clk(clk), .rst_n(rst_n), .rise(edge_vec), .coinc(coinc_pulse),
    .payload(payload), .frame_ready(frame_ready), .period_end(period_end),
    .coinc_run(coinc_run)
  );

  uart_frame_tx #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .BAUD_DIV(BAUD_DIV)) u_tx (
    .clk(clk), .rst_n(rst_n), .frame_ready(frame_ready), .payload(payload),
    .tx(uart_tx), .busy(tx_busy), .overflow(overflow)
  );

endmodule

// File: rtl/coinc_counter_chk.sv
module coinc_counter_chk #(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] ch_en,
  input logic [NUM_CH-1:0] edge_vec,
  input logic [NUM_CH-1:0] armed_vec,
  input logic              coinc_pulse,
  input logic              period_end,
  input logic              frame_ready,
  input logic              tx_busy,
  input logic              uart_tx,
  input logic              overflow,
  input logic [CNT_W-1:0]  coinc_run
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  a_r1_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (|edge_vec) |=> ((edge_vec & $past(edge_vec)) == '0));

  a_r4_disarm: assert property (@(posedge clk) disable iff (!rst_n)
    coinc_pulse |=> (armed_vec == '0));

  a_r5_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    coinc_pulse |-> (ch_en != '0));

  a_r6_period_clear: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |=> (coinc_run == '0));

  a_r7_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    ((coinc_run == CNT_MAX) && !period_end) |=> (coinc_run == CNT_MAX));

  a_r9_stop_high: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_busy) |-> uart_tx);

  a_r10_drop_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_ready && tx_busy) |=> overflow);

  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

endmodule

bind coinc_counter_top coinc_counter_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .edge_vec(edge_vec),
  .armed_vec(armed_vec), .coinc_pulse(coinc_pulse), .period_end(period_end),
  .frame_ready(frame_ready), .tx_busy(tx_busy), .uart_tx(uart_tx),
  .overflow(overflow), .coinc_run(coinc_run)
);

// File: tb/coinc_counter_top_tb.sv
module uart_sniff #(
  parameter int BAUD = 4
) (
  input  logic       clk,
  input  logic       line,
  output logic [7:0] data,
  output logic       stb,
  output logic       bad_stop
);
  initial begin
    logic [7:0] d;
    stb = 1'b0; data = '0; bad_stop = 1'b0; d = '0;
    forever begin
      @(negedge clk);
      if (line === 1'b0) begin
        repeat (BAUD / 2) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
          repeat (BAUD) @(negedge clk);
          d[i] = line;
        end
        repeat (BAUD) @(negedge clk);
        bad_stop = (line !== 1'b1);
        data = d;
        stb = 1'b1;
        @(negedge clk);
        stb = 1'b0;
      end
    end
  end
endmodule

module coinc_counter_top_tb;

  localparam int CLK_PERIOD = 10;
  localparam int PER  = 1000;
  localparam int BD   = 4;
  localparam int APER = 600;
  localparam int ABD  = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic [1:0] det = '0;
  logic [1:0] en = 2'b11;
  logic [3:0] win = 4'd3;
  logic m_tx, m_ovf;

  logic [2:0] a_det = '0;
  logic a_tx, a_ovf;

  coinc_counter_top #(.NUM_CH(2), .CNT_W(32), .WIN_W(4), .PERIOD_CYCLES(PER), .BAUD_DIV(BD)) u_dut (
    .clk(clk), .rst_n(rst_n), .det_in(det), .ch_en(en), .win_len(win),
    .uart_tx(m_tx), .overflow(m_ovf)
  );

  coinc_counter_top #(.NUM_CH(3), .CNT_W(8), .WIN_W(4), .PERIOD_CYCLES(APER), .BAUD_DIV(ABD)) u_dut_aux (
    .clk(clk), .rst_n(rst_n), .det_in(a_det), .ch_en(3'b111), .win_len(4'd2),
    .uart_tx(a_tx), .overflow(a_ovf)
  );

  logic [7:0] m_data, a_data;
  logic m_stb, a_stb, m_bad, a_bad;
  uart_sniff #(.BAUD(BD))  u_mon_m (.clk(clk), .line(m_tx), .data(m_data), .stb(m_stb), .bad_stop(m_bad));
  uart_sniff #(.BAUD(ABD)) u_mon_a (.clk(clk), .line(a_tx), .data(a_data), .stb(a_stb), .bad_stop(a_bad));

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];
  string tag_q[$];
  logic [7:0] a_bytes[5];
  int a_cnt = 0;

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_until(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  // Scoreboard driver side: the expected frame of one period
  task automatic push_frame(input int c0, input int c1, input int cc, input string tag);
    int v[3];
    v[0] = c0; v[1] = c1; v[2] = cc;
    exp_q.push_back(8'hA5); tag_q.push_back({tag, " R8 sync"});
    foreach (v[k]) for (int b = 0; b < 4; b++) begin
      exp_q.push_back(8'((v[k] >> (8 * b)) & 8'hFF));
      tag_q.push_back(tag);
    end
  endtask

  // Edge on channel a, then on channel b d cycles later
  task automatic pair(input int a, input int b, input int d);
    for (int t = 0; t <= d; t++) begin
      @(negedge clk);
      det[a] = (t == 0);
      det[b] = (t == d);
    end
    @(negedge clk);
    det = '0;
  endtask

  task automatic pulse(input logic [1:0] m);
    @(negedge clk); det = m;
    @(negedge clk); det = '0;
  endtask

  task automatic gap(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Scoreboard monitor side
  initial forever begin
    @(posedge m_stb);
    if (exp_q.size() == 0) begin
      check(1'b0, "R6 unexpected byte", 32'(m_data), 32'h0);
    end else begin
      logic [7:0] eb;
      string tg;
      eb = exp_q.pop_front();
      tg = tag_q.pop_front();
      check(m_data == eb, tg, 32'(m_data), 32'(eb));
    end
    check(!m_bad, "R9 stop bit", 32'(m_bad), 32'h0);
  end

  always @(posedge a_stb) begin
    if (a_cnt < 5) a_bytes[a_cnt] = a_data;
    a_cnt = a_cnt + 1;
  end

  initial begin
    repeat (30000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R6 actual=%0d expected=%0d", exp_q.size(), 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(m_tx == 1'b1, "R11 idle line after reset", 32'(m_tx), 32'h1);
    check(m_ovf == 1'b0, "R11 overflow clear after reset", 32'(m_ovf), 32'h0);
    fork
      begin
        // period 0: no stimulus, all counts zero (R11)
        push_frame(0, 0, 0, "R11 R6 empty period");
        // period 1: window 3, separations 0,2,3 hit; 4,7 miss; reverse order 2 hits
        wait_until(PER + 50);
        win = 4'd3; en = 2'b11;
        push_frame(6, 6, 4, "R3 R2 window edges");
        pair(0, 1, 0); gap(40);
        pair(0, 1, 2); gap(40);
        pair(0, 1, 3); gap(40);
        pair(0, 1, 4); gap(40);
        pair(0, 1, 7); gap(40);
        pair(1, 0, 2); gap(40);
        // period 2: long pulse on ch0 counted once (R1)
        wait_until(2 * PER + 50);
        push_frame(1, 1, 1, "R1 pulse width");
        @(negedge clk); det[0] = 1'b1;
        gap(2); det[1] = 1'b1;
        gap(1); det[1] = 1'b0;
        gap(48); det[0] = 1'b0;
        // period 3: only ch0 enabled, each ch0 edge is a coincidence (R5)
        wait_until(3 * PER + 50);
        en = 2'b01;
        push_frame(3, 2, 3, "R5 single enabled channel");
        pulse(2'b01); gap(30);
        pulse(2'b10); gap(30);
        pulse(2'b01); gap(30);
        pulse(2'b10); gap(30);
        pulse(2'b01); gap(30);
        // period 4: window 15; 15 hits, 16 misses, re-arm, no double count (R3 R4)
        wait_until(4 * PER + 50);
        en = 2'b11; win = 4'd15;
        push_frame(4, 4, 2, "R3 R4 wide window");
        pair(0, 1, 15);
        pulse(2'b10); gap(60);
        pair(0, 1, 16); gap(60);
        pulse(2'b01); gap(8);
        pair(0, 1, 14); gap(60);
        // period 5: setting 0 acts as 1 (R3)
        wait_until(5 * PER + 50);
        win = 4'd0;
        push_frame(2, 2, 1, "R3 zero window");
        pair(0, 1, 1); gap(40);
        pair(0, 1, 2); gap(40);
        // period 6: no channel enabled, never a coincidence (R5)
        wait_until(6 * PER + 50);
        en = 2'b00; win = 4'd3;
        push_frame(1, 1, 0, "R5 none enabled");
        pair(0, 1, 0); gap(40);
      end
      begin
        // second instance: 3 channels, 8-bit counts, short period
        wait_until(20);
        for (int i = 0; i < 260; i++) begin
          @(negedge clk); a_det[0] = 1'b1;
          @(negedge clk); a_det[0] = 1'b0;
        end
        wait_until(1100);
        check(a_ovf == 1'b0, "R10 no overflow before overrun", 32'(a_ovf), 32'h0);
        wait_until(1300);
        check(a_ovf == 1'b1, "R10 overflow on dropped frame", 32'(a_ovf), 32'h1);
        wait_until(2000);
        check(a_ovf == 1'b1, "R10 overflow sticky", 32'(a_ovf), 32'h1);
      end
    join
    for (int i = 0; i < 3000 && exp_q.size() != 0; i++) @(negedge clk);
    check(exp_q.size() == 0, "R6 all frames received", 32'(exp_q.size()), 32'h0);
    check(a_cnt >= 5, "R8 aux frame received", 32'(a_cnt), 32'h5);
    check(a_bytes[0] == 8'hA5, "R8 aux sync byte", 32'(a_bytes[0]), 32'hA5);
    check(a_bytes[1] == 8'hFF, "R7 saturated ch0", 32'(a_bytes[1]), 32'hFF);
    check(a_bytes[2] == 8'h00, "R8 aux ch1", 32'(a_bytes[2]), 32'h0);
    check(a_bytes[3] == 8'h00, "R8 aux ch2", 32'(a_bytes[3]), 32'h0);
    check(a_bytes[4] == 8'h00, "R8 aux coincidences", 32'(a_bytes[4]), 32'h0);
    check(m_ovf == 1'b0, "R10 no overflow when period exceeds frame", 32'(m_ovf), 32'h0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule